// File: doc/BRIEF.md
# Banked ROM/RAM Address Mapper

This block sits between a 16-bit CPU address bus and the memories of a small system. It turns each CPU address into either a banked ROM address or an 8 KB RAM address, and it holds the bank registers that software writes near the top of the address space. The lower 48 KB of the CPU space is split into three 16 KB windows. Each window shows the ROM bank named by its own bank register. The upper 16 KB is RAM, which appears twice.

The address outputs are purely combinational from the CPU address and the current register contents. Register writes take effect at the clock edge that samples the write strobe. The very bottom 1 KB of the CPU space always shows ROM bank 0, so startup and interrupt code stays reachable whatever bank software places in window 0. A write to the register addresses also lands in the RAM copy beneath them.

The top-of-space select register is latched, and one of its bits is brought out to drive an external cartridge-RAM path.

Top module: `mem_page_mapper`

## Requirements
- R1: `rom_sel` is 1 for every address below 0xC000 and 0 from 0xC000 upward. While `rom_sel` is 0, `rom_addr` is all zeros.
- R2: For an address from 0x0400 to 0xBFFF, `rom_addr` is {bank, address[13:0]}. The bank comes from the register of the window selected by address[15:14]: value 0 selects window 0, 1 selects window 1, 2 selects window 2.
- R3: For an address from 0x0000 to 0x03FF, the bank field of `rom_addr` is 0, whatever window 0's register holds.
- R4: `ram_addr` always equals address[12:0], so 0xE000–0xFFFF reach the same RAM bytes as 0xC000–0xDFFF.
- R5: A write strobe at 0xFFFD, 0xFFFE or 0xFFFF loads `cpu_wdata` into the register for window 0, 1 or 2 respectively at that clock edge.
- R6: A write strobe at 0xFFFC latches `cpu_wdata` bit 3 into `cart_ram_en` at that clock edge.
- R7: A write below 0xC000 changes no register and leaves `ram_we` low.
- R8: `ram_we` equals `cpu_wr` for every address from 0xC000 to 0xFFFF, including the four register addresses.
- R9: Reset sets the window registers to 0, 1 and 2 and clears `cart_ram_en`.
- R10: Bank registers are 8 bits wide. The bank field is the low BANK_BITS bits of the register (5 by default), so higher bits are dropped.
- R11: With `cpu_wr` low, no register changes at any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| rom_sel | output | 1 | 1 for the ROM region, 0 for RAM |
| rom_addr | output | BANK_BITS+14 | Bank number concatenated with the 14-bit offset |
| ram_addr | output | 13 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| cart_ram_en | output | 1 | Latched cartridge-RAM select bit |

## Verification
The bench targets the 0x03FF/0x0400 boundary. A design that forgets the pin would show window 0's bank there, and a design with the limit off by one would pin the wrong byte. It writes bank values wider than BANK_BITS to catch a design that fails to drop the upper bits. It writes the register addresses and checks that `ram_we` rises at the same time, because a design that treats them as register-only would lose the RAM copy. It also writes below 0xC000 and issues register addresses with the strobe low, then reads each window back; a design that decodes the address without the strobe, or that lets low writes through, would show a moved bank.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int CPU_AW    = 16;
  localparam int DATA_W    = 8;
  localparam int OFS_W     = 14;
  localparam int RAM_AW    = 13;
  localparam int NUM_SLOTS = 3;

  localparam logic [CPU_AW-1:0] RAM_BASE      = 16'hC000;
  localparam logic [CPU_AW-1:0] PIN_LIMIT     = 16'h0400;
  localparam logic [CPU_AW-1:0] SEL_REG_ADDR  = 16'hFFFC;
  localparam logic [CPU_AW-1:0] PAGE_REG_BASE = 16'hFFFD;

  typedef enum logic [1:0] {
    WIN0    = 2'd0,
    WIN1    = 2'd1,
    WIN2    = 2'd2,
    WIN_RAM = 2'd3
  } window_e;

  function automatic window_e window_of(input logic [CPU_AW-1:0] a);
    return window_e'(a[CPU_AW-1 -: 2]);
  endfunction
endpackage

// File: rtl/mapper_rst_sync.sv
module mapper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 cpu_wr,
  output window_e              win,
  output logic                 in_rom,
  output logic                 pinned,
  output logic [NUM_SLOTS-1:0] page_wr_en,
  output logic                 sel_wr_en,
  output logic                 ram_wr_en
);
  always_comb begin
    win       = window_of(cpu_addr);
    in_rom    = (cpu_addr < RAM_BASE);
    pinned    = (cpu_addr < PIN_LIMIT);
    ram_wr_en = cpu_wr && !in_rom;
    sel_wr_en = cpu_wr && (cpu_addr == SEL_REG_ADDR);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_page_hit
    localparam logic [CPU_AW-1:0] HIT = PAGE_REG_BASE + CPU_AW'(i);
    assign page_wr_en[i] = cpu_wr && (cpu_addr == HIT);
  end
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int CART_BIT = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [DATA_W-1:0]                   wdata,
  input  logic [NUM_SLOTS-1:0]                page_wr_en,
  input  logic                                sel_wr_en,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]    pages,
  output logic                                cart_en
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] pages_d;
  logic                             cart_d;

  always_comb begin
    pages_d = pages;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (page_wr_en[i]) pages_d[i] = wdata;
    end
    cart_d = sel_wr_en ? wdata[CART_BIT] : cart_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) pages[i] <= DATA_W'(i);
      cart_en <= 1'b0;
    end else begin
      pages   <= pages_d;
      cart_en <= cart_d;
    end
  end

  // R5
  page_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(page_wr_en));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    // R5
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr_en[i] |=> (pages[i] == $past(wdata)));
  end

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr_en == '0) |=> $stable(pages));

  // R6
  cart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en |=> (cart_en == $past(wdata[CART_BIT])));
endmodule

// File: rtl/mapper_rom_addr.sv
module mapper_rom_addr
  import mapper_pkg::*;
#(
  parameter int BANK_BITS = 5,
  localparam int ROM_AW   = BANK_BITS + OFS_W
) (
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] pages,
  input  window_e                          win,
  input  logic                             in_rom,
  input  logic                             pinned,
  input  logic [OFS_W-1:0]                 offset,
  output logic [ROM_AW-1:0]                rom_addr
);
  logic [BANK_BITS-1:0] bank;

  always_comb begin
    bank = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(win) == i) bank = pages[i][BANK_BITS-1:0];
    end
    if (pinned) bank = '0;
    rom_addr = in_rom ? {bank, offset} : '0;
  end
endmodule

// File: rtl/mem_page_mapper.sv
module mem_page_mapper
  import mapper_pkg::*;
#(
  parameter int BANK_BITS  = 5,
  parameter int CART_BIT   = 3,
  parameter int SYNC_DEPTH = 2,
  localparam int ROM_AW    = BANK_BITS + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_wr,
  output logic               rom_sel,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [12:0]        ram_addr,
  output logic               ram_we,
  output logic               cart_ram_en
);
  logic                             srst_n;
  window_e                          win;
  logic                             in_rom;
  logic                             pinned;
  logic [NUM_SLOTS-1:0]             page_wr_en;
  logic                             sel_wr_en;
  logic                             ram_wr_en;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] pages;

  mapper_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mapper_decode u_dec (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .win(win), .in_rom(in_rom),
    .pinned(pinned), .page_wr_en(page_wr_en), .sel_wr_en(sel_wr_en),
    .ram_wr_en(ram_wr_en)
  );

  mapper_regs #(.CART_BIT(CART_BIT)) u_regs (
    .clk(clk), .rst_n(srst_n), .wdata(cpu_wdata), .page_wr_en(page_wr_en),
    .sel_wr_en(sel_wr_en), .pages(pages), .cart_en(cart_ram_en)
  );

  mapper_rom_addr #(.BANK_BITS(BANK_BITS)) u_rom (
    .pages(pages), .win(win), .in_rom(in_rom), .pinned(pinned),
    .offset(cpu_addr[OFS_W-1:0]), .rom_addr(rom_addr)
  );

  assign rom_sel  = in_rom;
  assign ram_addr = cpu_addr[RAM_AW-1:0];
  assign ram_we   = ram_wr_en;

  // R3
  pin_bank_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cpu_addr < PIN_LIMIT) |-> (rom_addr[ROM_AW-1:OFS_W] == '0));

  // R1
  ram_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rom_sel |-> (rom_addr == '0));

  // R8
  ram_we_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ram_we |-> (cpu_wr && !rom_sel));

  // R11
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !cpu_wr |=> ($stable(pages) && $stable(cart_ram_en)));
endmodule

// File: tb/mem_page_mapper_tb.sv
module mem_page_mapper_tb;
  localparam int BANK_BITS = 5;
  localparam int ROM_AW    = BANK_BITS + 14;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic              cpu_wr;
  logic              rom_sel;
  logic [ROM_AW-1:0] rom_addr;
  logic [12:0]       ram_addr;
  logic              ram_we;
  logic              cart_ram_en;

  int checks = 0;
  int errors = 0;
  int pg[3];
  int cart;

  always #4 clk = ~clk;

  mem_page_mapper #(.BANK_BITS(BANK_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_sel(rom_sel), .rom_addr(rom_addr),
    .ram_addr(ram_addr), .ram_we(ram_we), .cart_ram_en(cart_ram_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (addr=%h)", req, act, exp, cpu_addr);
    end
  endtask

  task automatic step(input int a, input int d, input bit w, input string tag);
    int bank;
    int exp_rom;
    string rt;
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = w;
    #1;
    if (a < 'h400) begin bank = 0; rt = "R3"; end
    else if (a < 'hC000) begin bank = pg[a / 'h4000] % (1 << BANK_BITS); rt = "R2"; end
    else begin bank = 0; rt = "R1"; end
    if (tag != "") rt = tag;
    exp_rom = (a < 'hC000) ? bank * 'h4000 + (a % 'h4000) : 0;
    chk("R1", int'(rom_sel), int'(a < 'hC000));
    chk(rt, int'(rom_addr), exp_rom);
    chk("R4", int'(ram_addr), a % 'h2000);
    chk((a >= 'hC000) ? "R8" : "R7", int'(ram_we), int'(w && a >= 'hC000));
    chk("R6", int'(cart_ram_en), cart);
    @(posedge clk);
    if (w) begin
      if (a == 'hFFFC) cart = (d >> 3) % 2;
      else if (a >= 'hFFFD) pg[a - 'hFFFD] = d % 256;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pg[0] = 0; pg[1] = 1; pg[2] = 2; cart = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset bank values and cartridge bit
    step('h0400, 0, 0, "R9");
    step('h4abc, 0, 0, "R9");
    step('hBFFF, 0, 0, "R9");
    // R5: load each window register
    step('hFFFD, 'h07, 1, "");
    step('hFFFE, 'h0C, 1, "");
    step('hFFFF, 'h1E, 1, "");
    step('h1234, 0, 0, "R5");
    step('h5678, 0, 0, "R5");
    step('h9ABC, 0, 0, "R5");
    // R3: pin boundary with window 0 holding a nonzero bank
    step('h0000, 0, 0, "R3");
    step('h03FF, 0, 0, "R3");
    step('h0400, 0, 0, "R2");
    // R10: upper bits of the bank register dropped
    step('hFFFE, 'hE5, 1, "");
    step('h7FFF, 0, 0, "R10");
    // R7: writes below RAM ignored
    step('h4000, 'h11, 1, "R7");
    step('hBFFF, 'h13, 1, "R7");
    step('h8000, 0, 0, "R7");
    // R11: register addresses without the strobe
    step('hFFFD, 'h03, 0, "R11");
    step('hFFFC, 'hFF, 0, "R11");
    step('h2000, 0, 0, "R11");
    // R6: cartridge bit set then cleared; R8 write-through at register address
    step('hFFFC, 'h08, 1, "");
    step('hFFFC, 'hF7, 1, "");
    step('hFFFC, 'h08, 1, "");
    // R4: mirror
    step('hE123, 0, 0, "");
    step('hC123, 'h55, 1, "");
    for (int n = 0; n < 2000; n++) begin
      int a;
      int sel;
      sel = int'($urandom % 8);
      if (sel == 0) a = 'hFFFC + int'($urandom % 4);
      else a = int'($urandom % 65536);
      step(a, int'($urandom % 256), bit'($urandom % 2), "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule